// File: doc/BRIEF.md
# Framed Word Serializer with Lock Interval and Resync

The block turns 10-bit parallel words into one serial bitstream that carries its own clock. Each word goes out as a 12-bit frame. A start bit of 1 comes first, then the ten data bits with the least significant bit first, and last a stop bit of 0. Every frame therefore holds a 0-to-1 edge at its boundary, and a receiver can lock to that edge. The bits advance on a bit-rate clock enable, `bit_en`, which the system asserts twelve times per word period. The word rate is the bit rate divided by twelve, so payload throughput is ten twelfths of the line rate.

After reset the serial output is disabled (`ser_oe` low, which drives an external tri-state buffer to high impedance) for a fixed lock interval of `LOCK_WORDS` word periods. Only after that interval does the block raise `ready` and begin sending user words.

A synchronous `resync` request disables the output at once. When the request is released, the block re-enables the output at the next frame boundary. It then sends a programmable number of frames whose data bits are all zero, so the far end can lock again. After those frames it takes user words once more.

Top module: `framed_serializer`

## Requirements
- R1: While enabled, the output carries frame bit j during frame position j. Position 0 is the start bit, positions 1 to 10 carry `word_in` bit 0 up to bit 9 (least significant bit first), and position 11 is the stop bit. Each position lasts from one `bit_en` edge to the next.
- R2: The start bit (position 0) is always 1 and the stop bit (position 11) is always 0.
- R3: The frame position advances by one only on a clock edge with `bit_en` high, and wraps from 11 to 0. `word_due` is high exactly while the position is 11.
- R4: A user word is taken from `word_in` only on the clock edge where `word_due` and `bit_en` are both high. The new frame starts at position 0 after that edge.
- R5: During reset and afterwards until the lock interval ends, `ready` and `ser_oe` are low and no frame is sent.
- R6: `ready` and `ser_oe` rise on the edge of the `LOCK_WORDS`-th word boundary after reset (default 2049). The frame started on that edge carries the `word_in` captured there.
- R7: Once high, `ready` stays high until the next reset, including while `resync` is high.
- R8: After `ready` is high, a clock edge with `resync` high forces `ser_oe` low from that edge on. `ser_oe` stays low while `resync` stays high.
- R9: After `resync` is released, `ser_oe` rises at the next word boundary. The block then sends `zero_cnt` framed frames with all-zero data, where a value of 0 counts as 1, and after them resumes user words. A `resync` during these zero frames restarts the hold.
- R10: `resync` has no effect during the lock interval.
- R11: `ser_out` is 0 whenever `ser_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable, twelve per word period |
| word_in | input | 10 | Parallel data word |
| zero_cnt | input | ZC_W | Number of zero frames after a resync (0 means 1) |
| resync | input | 1 | Resynchronization request, level sensitive |
| word_due | output | 1 | High during the last frame position; the next `bit_en` edge takes `word_in` |
| ser_out | output | 1 | Serial bit |
| ser_oe | output | 1 | Output enable for the line driver |
| ready | output | 1 | Lock interval completed |

## Verification
The bench runs the whole lock interval and places a `resync` pulse inside it. A design that miscounts the interval, or that honours the early pulse, would raise `ready` on the wrong word boundary. Stall cycles on `bit_en` catch a shifter that advances on the clock instead of the enable, and the bench watches the start and stop positions to catch a frame that loses the start edge. Resync with `zero_cnt` set to 0, 1, 2 and 3, and a second request arriving inside the zero frames, expose an off-by-one in the zero-frame count, a zero count that sends nothing, and a re-enable placed in the middle of a frame. All-ones and all-zero words expose bit-order or framing slips.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int SER_DATA_W  = 10;
    localparam int SER_FRAME_W = SER_DATA_W + 2;
    localparam int FPOS_W      = $clog2(SER_FRAME_W);

    localparam logic MARK_START = 1'b1;
    localparam logic MARK_STOP  = 1'b0;

    typedef logic [SER_DATA_W-1:0]  word_t;
    typedef logic [SER_FRAME_W-1:0] frame_t;
    typedef logic [FPOS_W-1:0]      fpos_t;

    typedef enum logic [1:0] {
        LS_INIT  = 2'd0,
        LS_DATA  = 2'd1,
        LS_HOLD  = 2'd2,
        LS_ZFILL = 2'd3
    } link_state_t;

    // Bit 0 leaves the line first: start mark, data LSB first, stop mark.
    function automatic frame_t build_frame(input word_t w);
        return {MARK_STOP, w, MARK_START};
    endfunction

endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer
    import ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    output fpos_t pos,
    output logic  last,
    output logic  wtick
);
    localparam fpos_t LAST_POS = fpos_t'(SER_FRAME_W - 1);

    fpos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (bit_en) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + fpos_t'(1);
        end
    end

    assign pos   = pos_q;
    assign last  = (pos_q == LAST_POS);
    assign wtick = bit_en & last;

endmodule

// File: rtl/ser_lock_count.sv
module ser_lock_count #(
    parameter int LOCK_WORDS = 2049
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LOCK_WORDS > 2) ? $clog2(LOCK_WORDS) : 1;
    localparam logic [CW-1:0] TOP = CW'(LOCK_WORDS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = tick && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick && !expire) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/ser_link_ctrl.sv
module ser_link_ctrl
    import ser_pkg::*;
#(
    parameter int ZC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wtick,
    input  logic            expire,
    input  logic            resync,
    input  logic [ZC_W-1:0] zero_cnt,
    output logic            load,
    output logic            load_zero,
    output logic            oe,
    output logic            ready,
    output logic            lock_tick
);
    link_state_t     st_q;
    logic [ZC_W-1:0] zl_q;
    logic            oe_q;

    assign ready     = (st_q != LS_INIT);
    assign oe        = oe_q;
    assign lock_tick = wtick && (st_q == LS_INIT);

    always_comb begin
        load      = 1'b0;
        load_zero = 1'b0;
        unique case (st_q)
            LS_INIT:  load = wtick && expire;
            LS_DATA:  load = wtick && !resync;
            LS_HOLD:  begin
                load      = wtick && !resync;
                load_zero = 1'b1;
            end
            LS_ZFILL: begin
                load      = wtick && !resync;
                load_zero = (zl_q != '0);
            end
            default:  load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LS_INIT;
            zl_q <= '0;
            oe_q <= 1'b0;
        end else begin
            unique case (st_q)
                LS_INIT: begin
                    if (wtick && expire) begin
                        st_q <= LS_DATA;
                        oe_q <= 1'b1;
                    end
                end
                LS_DATA: begin
                    if (resync) begin
                        st_q <= LS_HOLD;
                        oe_q <= 1'b0;
                    end
                end
                LS_HOLD: begin
                    if (!resync && wtick) begin
                        st_q <= LS_ZFILL;
                        oe_q <= 1'b1;
                        zl_q <= (zero_cnt == '0) ? '0 : zero_cnt - ZC_W'(1);
                    end
                end
                LS_ZFILL: begin
                    if (resync) begin
                        st_q <= LS_HOLD;
                        oe_q <= 1'b0;
                    end else if (wtick) begin
                        if (zl_q == '0) st_q <= LS_DATA;
                        else            zl_q <= zl_q - ZC_W'(1);
                    end
                end
                default: st_q <= LS_INIT;
            endcase
        end
    end

endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
    import ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  load_zero,
    input  logic  shift,
    input  word_t word_in,
    output logic  bit_out
);
    frame_t sr_q;
    word_t  src;

    assign src = load_zero ? '0 : word_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= build_frame(src);
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[SER_FRAME_W-1:1]};
        end
    end

    assign bit_out = sr_q[0];

endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
    import ser_pkg::*;
#(
    parameter int LOCK_WORDS = 2049,
    parameter int ZC_W       = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic [SER_DATA_W-1:0] word_in,
    input  logic [ZC_W-1:0]       zero_cnt,
    input  logic                  resync,
    output logic                  word_due,
    output logic                  ser_out,
    output logic                  ser_oe,
    output logic                  ready
);
    fpos_t frame_pos;
    logic  word_tick;
    logic  lock_tick;
    logic  lock_expire;
    logic  load;
    logic  load_zero;
    logic  oe;
    logic  line_bit;

    ser_bit_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .bit_en(bit_en),
        .pos   (frame_pos),
        .last  (word_due),
        .wtick (word_tick)
    );

    ser_lock_count #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .tick  (lock_tick),
        .expire(lock_expire)
    );

    ser_link_ctrl #(.ZC_W(ZC_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wtick    (word_tick),
        .expire   (lock_expire),
        .resync   (resync),
        .zero_cnt (zero_cnt),
        .load     (load),
        .load_zero(load_zero),
        .oe       (oe),
        .ready    (ready),
        .lock_tick(lock_tick)
    );

    ser_frame_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_zero(load_zero),
        .shift    (bit_en & ~word_tick),
        .word_in  (word_in),
        .bit_out  (line_bit)
    );

    assign ser_oe  = oe;
    assign ser_out = oe & line_bit;

endmodule

// File: rtl/ser_checker.sv
module ser_checker
    import ser_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bit_en,
    input logic  resync,
    input logic  ser_out,
    input logic  ser_oe,
    input logic  ready,
    input fpos_t pos
);
    localparam fpos_t LAST_POS = fpos_t'(SER_FRAME_W - 1);

    a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && pos == '0) |-> ser_out);

    a_r2_stop_low: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && pos == LAST_POS) |-> !ser_out);

    a_r3_pos_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(pos));

    a_r5_off_until_ready: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !ser_oe);

    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r8_resync_off: assert property (@(posedge clk) disable iff (rst)
        (resync && ready) |=> !ser_oe);

    a_r9_enable_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> (pos == '0));

endmodule

bind framed_serializer ser_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .resync (resync),
    .ser_out(ser_out),
    .ser_oe (ser_oe),
    .ready  (ready),
    .pos    (frame_pos)
);

// File: tb/framed_serializer_test.sv
`timescale 1ns/1ps
module framed_serializer_test;

    localparam int LOCK = 2049;
    localparam int ZCW  = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bit_en = 1'b0;
    logic [9:0]     word_in = '0;
    logic [ZCW-1:0] zero_cnt = '0;
    logic           resync = 1'b0;
    logic           word_due, ser_out, ser_oe, ready;

    framed_serializer #(.LOCK_WORDS(LOCK), .ZC_W(ZCW)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
        .zero_cnt(zero_cnt), .resync(resync), .word_due(word_due),
        .ser_out(ser_out), .ser_oe(ser_oe), .ready(ready)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side expectation state, advanced once per clock edge.
    int         m_idx = 0;
    int         m_st  = 0;   // 0 lock, 1 data, 2 hold, 3 zero fill
    int         m_wc  = 0;
    int         m_zl  = 0;
    bit         m_oe  = 1'b0;
    logic [11:0] m_fr = '0;

    function automatic logic [11:0] frame_of(input logic [9:0] w);
        return {1'b0, w, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails < 20) $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit wt;
        if (rst) begin
            m_idx = 0; m_st = 0; m_wc = 0; m_zl = 0; m_oe = 1'b0; m_fr = '0;
            return;
        end
        wt = bit_en && (m_idx == 11);
        if (bit_en) m_idx = (m_idx == 11) ? 0 : m_idx + 1;
        case (m_st)
            0: if (wt) begin
                   if (m_wc == LOCK - 1) begin m_st = 1; m_oe = 1'b1; m_fr = frame_of(word_in); end
                   else m_wc++;
               end
            1: if (resync) begin m_st = 2; m_oe = 1'b0; end
               else if (wt) m_fr = frame_of(word_in);
            2: if (!resync && wt) begin
                   m_st = 3; m_oe = 1'b1; m_fr = frame_of('0);
                   m_zl = (zero_cnt == 0) ? 0 : int'(zero_cnt) - 1;
               end
            default: if (resync) begin m_st = 2; m_oe = 1'b0; end
               else if (wt) begin
                   if (m_zl == 0) begin m_st = 1; m_fr = frame_of(word_in); end
                   else begin m_zl--; m_fr = frame_of('0); end
               end
        endcase
    endtask

    task automatic compare();
        bit exp_out;
        exp_out = m_oe ? m_fr[m_idx] : 1'b0;
        chk(ready == (m_st != 0), "R6 R7 R10 ready", int'(ready), int'(m_st != 0));
        chk(ser_oe == m_oe, (m_st == 2) ? "R8 ser_oe" : "R5 R6 R9 ser_oe", int'(ser_oe), int'(m_oe));
        chk(word_due == (m_idx == 11), "R3 word_due", int'(word_due), int'(m_idx == 11));
        if (!m_oe)            chk(ser_out == exp_out, "R11 ser_out", int'(ser_out), int'(exp_out));
        else if (m_idx == 0 || m_idx == 11)
                              chk(ser_out == exp_out, "R2 frame mark", int'(ser_out), int'(exp_out));
        else if (m_st == 3)   chk(ser_out == exp_out, "R9 zero frame bit", int'(ser_out), int'(exp_out));
        else                  chk(ser_out == exp_out, "R1 R4 data bit", int'(ser_out), int'(exp_out));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic rand_inputs(input bit stall);
        bit_en  = stall ? (($urandom % 4) != 0) : 1'b1;
        word_in = 10'($urandom);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) cycle();
        // R5: reset state at the ports
        chk(ready == 1'b0 && ser_oe == 1'b0 && ser_out == 1'b0, "R5 reset state",
            int'({ready, ser_oe, ser_out}), 0);
        rst = 1'b0;

        // Lock interval at full bit rate, with a resync pulse that must be ignored (R10).
        for (int i = 0; i < LOCK * 12 + 120; i++) begin
            rand_inputs(1'b0);
            resync = (i >= 100 && i < 140);
            cycle();
        end
        resync = 1'b0;
        chk(ready == 1'b1, "R6 ready after lock", int'(ready), 1);

        // Directed corner words with enable stalls (R1 R4).
        for (int i = 0; i < 400; i++) begin rand_inputs(1'b1); word_in = 10'h3FF; cycle(); end
        for (int i = 0; i < 400; i++) begin rand_inputs(1'b1); word_in = 10'h000; cycle(); end
        for (int i = 0; i < 400; i++) begin rand_inputs(1'b1); word_in = 10'h2AA; cycle(); end
        for (int i = 0; i < 2000; i++) begin rand_inputs(1'b1); cycle(); end

        // Resync with several zero-frame counts (R8 R9), 0 counts as 1.
        for (int k = 0; k < 4; k++) begin
            zero_cnt = (k == 0) ? 4'd0 : (k == 1) ? 4'd1 : (k == 2) ? 4'd3 : 4'd2;
            for (int i = 0; i < 30; i++) begin rand_inputs(1'b1); resync = 1'b1; cycle(); end
            resync = 1'b0;
            for (int i = 0; i < 16 * 12 * (int'(zero_cnt) + 3); i++) begin rand_inputs(1'b1); cycle(); end
        end

        // Resync arriving inside the zero frames (R9 restart).
        zero_cnt = 4'd3;
        for (int i = 0; i < 10; i++) begin rand_inputs(1'b1); resync = 1'b1; cycle(); end
        resync = 1'b0;
        for (int i = 0; i < 40; i++) begin rand_inputs(1'b1); cycle(); end
        for (int i = 0; i < 3; i++) begin rand_inputs(1'b1); resync = 1'b1; cycle(); end
        resync = 1'b0;
        for (int i = 0; i < 1200; i++) begin rand_inputs(1'b1); cycle(); end
        chk(ready == 1'b1, "R7 ready kept after resyncs", int'(ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule